// File: doc/BRIEF.md
# SIMD Rounding Shift-Right Unit

This block is a lane-parallel datapath that divides every lane of a 64-bit or 128-bit operand by a power of two and rounds the quotient half-up. A 7-bit control field sets both the lane width and the shift count. The field is the single `l` bit placed above the six-bit `imm6` input. A signedness bit picks unsigned or two's-complement lanes. A quad bit picks one or two 64-bit words. Every lane is extended by one bit and the rounding constant is added to it. The sum is then shifted and cut back to the lane width, and the lanes are packed into the result word.

The block also checks the instruction fields it is given. A control field whose four upper bits are all zero belongs to a different operation. It raises `other_enc_flag` and the result is forced to zero. A quad operation with an odd source or destination register number raises `undef_flag`, and its result is also forced to zero. All outputs are registered and appear on the clock edge after an `in_valid` strobe. Between strobes the outputs hold their last values.

Top module: `simd_rshr_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low otherwise. A synchronous active-high `rst` clears `out_valid`, `result`, `undef_flag` and `other_enc_flag`.
- R2: Let F = {l, imm6} (7 bits). The lane width is 8 << k, where k is the index (0..3) of the highest set bit among F[6:3]. So F[6]=1 gives 64-bit lanes, F[5] gives 32-bit, F[4] gives 16-bit and F[3] gives 8-bit lanes.
- R3: The shift count is 2·width − F, with legal values from 1 to the lane width. Both extremes are supported.
- R4: Each lane result is (x + 2^(s−1)) >> s, worked out one bit wider than the lane, keeping the low lane-width bits. A full-width shift therefore returns only the carry. For example, an unsigned 64-bit lane of all ones shifted by 64 gives 1, and an unsigned 8-bit lane 0x80 shifted by 8 gives 1.
- R5: `u`=1 treats lanes as unsigned (zero extension, logical shift). `u`=0 treats them as two's complement (sign extension, arithmetic shift).
- R6: Lane e of each 64-bit word sits in bits [e·w+w−1 : e·w]. Lanes are processed independently, with no carry between them.
- R7: With `q`=0 only operand[63:0] is processed and result[127:64] is zero. With `q`=1 both 64-bit words are processed the same way.
- R8: With `q`=1 and `vd0` or `vm0` high, `undef_flag` is set and `result` is zero. With `q`=0 the register bits have no effect.
- R9: When F[6:3] = 0, `other_enc_flag` is set and `result` is zero.
- R10: While `in_valid` is low, `result`, `undef_flag` and `other_enc_flag` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| u | input | 1 | 1 = unsigned lanes, 0 = signed lanes |
| l | input | 1 | Top bit of the control field |
| imm6 | input | 6 | Lower six bits of the control field |
| q | input | 1 | 1 = 128-bit operation, 0 = 64-bit |
| vd0 | input | 1 | Bit 0 of the destination register number |
| vm0 | input | 1 | Bit 0 of the source register number |
| operand | input | 128 | Source vector |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 128 | Rounded, shifted lanes |
| undef_flag | output | 1 | Odd register number on a quad operation |
| other_enc_flag | output | 1 | Control field belongs to another operation |

## Verification
The operand patterns mix 0x80, 0x7F and 0xFF bytes with random-looking words. This tells a signed lane apart from an unsigned one, and shows whether rounding carries stay inside their lane. Every lane width is run with a shift of 1, where only the round bit matters, and with the full lane width, where only the carry survives. Mid-range shifts show whether the shift count comes from the field arithmetic or from the lane width alone. Quad and single operations with a loaded upper word, both flag cases and an idle cycle with a changed operand separate the masking and hold paths from the arithmetic.

// File: rtl/simd_rshr_pkg.sv
package simd_rshr_pkg;

  localparam int FIELD_W = 7;
  localparam int SHIFT_W = 8;
  localparam int LANE_MAX = 64;
  localparam int EXT_W = LANE_MAX + 2;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } esz_e;

  typedef struct packed {
    esz_e               sz;
    logic [SHIFT_W-1:0] shift;
    logic               uns;
    logic               foreign;
    logic               bad_reg;
  } ctl_t;

  // Highest set bit among the upper four field bits picks the lane width.
  function automatic esz_e size_of(logic [3:0] top);
    if (top[3])      return SZ_D;
    else if (top[2]) return SZ_W;
    else if (top[1]) return SZ_H;
    else             return SZ_B;
  endfunction

  // One lane: extend, add rounding constant, shift, keep lane width.
  function automatic logic [LANE_MAX-1:0] lane_round(logic [LANE_MAX-1:0] v, int ew,
                                                     logic [SHIFT_W-1:0] sh, logic uns);
    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] sum;
    logic [EXT_W-1:0] shifted;
    logic [LANE_MAX-1:0] res;
    logic fill;
    fill = uns ? 1'b0 : v[ew-1];
    for (int i = 0; i < LANE_MAX; i++) ext[i] = (i < ew) ? v[i] : fill;
    ext[EXT_W-2] = fill;
    ext[EXT_W-1] = fill;
    sum = ext + (EXT_W'(1) << (sh - SHIFT_W'(1)));
    shifted = $signed(sum) >>> sh;
    for (int i = 0; i < LANE_MAX; i++) res[i] = (i < ew) ? shifted[i] : 1'b0;
    return res;
  endfunction

endpackage

// File: rtl/rshr_decode.sv
module rshr_decode
  import simd_rshr_pkg::*;
(
  input  logic       l,
  input  logic [5:0] imm6,
  input  logic       u,
  input  logic       q,
  input  logic       vd0,
  input  logic       vm0,
  output ctl_t       ctl
);
  logic [FIELD_W-1:0] field;
  esz_e               sz;

  assign field = {l, imm6};
  assign sz    = size_of(field[6:3]);

  always_comb begin
    ctl.sz      = sz;
    ctl.shift   = (SHIFT_W'(16) << sz) - {1'b0, field};
    ctl.uns     = u;
    ctl.foreign = (field[6:3] == 4'd0);
    ctl.bad_reg = q & (vd0 | vm0);
  end
endmodule

// File: rtl/rshr_word.sv
module rshr_word
  import simd_rshr_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic [WORD_W-1:0]  word,
  input  esz_e               sz,
  input  logic [SHIFT_W-1:0] shift,
  input  logic               uns,
  output logic [WORD_W-1:0]  res
);
  localparam int NSIZES = 4;

  logic [WORD_W-1:0] variant [NSIZES];

  for (genvar k = 0; k < NSIZES; k++) begin : g_size
    localparam int EW = 8 << k;
    localparam int NL = WORD_W / EW;
    for (genvar j = 0; j < NL; j++) begin : g_lane
      logic [LANE_MAX-1:0] lane_out;
      assign lane_out = lane_round(LANE_MAX'(word[j*EW +: EW]), EW, shift, uns);
      assign variant[k][j*EW +: EW] = lane_out[EW-1:0];
    end
  end

  assign res = variant[sz];
endmodule

// File: rtl/simd_rshr_unit.sv
module simd_rshr_unit
  import simd_rshr_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int WORDS  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    u,
  input  logic                    l,
  input  logic [5:0]              imm6,
  input  logic                    q,
  input  logic                    vd0,
  input  logic                    vm0,
  input  logic [WORDS*WORD_W-1:0] operand,
  output logic                    out_valid,
  output logic [WORDS*WORD_W-1:0] result,
  output logic                    undef_flag,
  output logic                    other_enc_flag
);
  localparam int TOTAL_W = WORDS * WORD_W;

  ctl_t               ctl;
  logic [TOTAL_W-1:0] raw;
  logic [WORDS-1:0]   word_on;
  logic               reject;
  logic [TOTAL_W-1:0] next_result;

  rshr_decode u_dec (
    .l(l), .imm6(imm6), .u(u), .q(q), .vd0(vd0), .vm0(vm0), .ctl(ctl)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_res;
    rshr_word #(.WORD_W(WORD_W)) u_word (
      .word(operand[w*WORD_W +: WORD_W]),
      .sz(ctl.sz),
      .shift(ctl.shift),
      .uns(ctl.uns),
      .res(word_res)
    );
    assign word_on[w] = (w == 0) ? 1'b1 : q;
    assign raw[w*WORD_W +: WORD_W] = word_on[w] ? word_res : '0;
  end

  assign reject      = ctl.foreign | ctl.bad_reg;
  assign next_result = reject ? '0 : raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      result         <= '0;
      undef_flag     <= 1'b0;
      other_enc_flag <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result         <= next_result;
        undef_flag     <= ctl.bad_reg;
        other_enc_flag <= ctl.foreign;
      end
    end
  end
endmodule

// File: rtl/rshr_checker.sv
module rshr_checker #(
  parameter int WORD_W = 64,
  parameter int WORDS  = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    l,
  input logic [5:0]              imm6,
  input logic                    q,
  input logic                    vd0,
  input logic                    vm0,
  input logic                    out_valid,
  input logic [WORDS*WORD_W-1:0] result,
  input logic                    undef_flag,
  input logic                    other_enc_flag
);
  p_reset_r1: assert property (@(posedge clk) rst |=> !out_valid && !undef_flag);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && !q |=> result[WORDS*WORD_W-1:WORD_W] == '0);
  p_undef_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && q && (vd0 || vm0) |=> undef_flag && result == '0);
  p_no_undef_r8: assert property (@(posedge clk) disable iff (rst) in_valid && !q |=> !undef_flag);
  p_foreign_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && !l && imm6[5:3] == 3'b000 |=> other_enc_flag && result == '0);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(undef_flag) && $stable(other_enc_flag));
endmodule

bind simd_rshr_unit rshr_checker #(.WORD_W(WORD_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .l(l), .imm6(imm6), .q(q),
  .vd0(vd0), .vm0(vm0), .out_valid(out_valid), .result(result),
  .undef_flag(undef_flag), .other_enc_flag(other_enc_flag)
);

// File: tb/simd_rshr_unit_test.sv
module simd_rshr_unit_test;
  localparam int PERIOD = 10;
  localparam int NVEC = 13;

  // Stimulus: {u, l, imm6, q, vd0, vm0, operand}
  localparam logic [138:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 6'b001111, 1'b0, 1'b0, 1'b0, 128'h55AA_0000_1111_2222_0123_4567_89AB_CDEF},
    {1'b0, 1'b0, 6'b001101, 1'b1, 1'b0, 1'b0, 128'h8081_7F7E_FFFE_0103_F0E1_D2C3_B4A5_9687},
    {1'b0, 1'b0, 6'b001000, 1'b1, 1'b0, 1'b0, 128'h807F_FF00_01C0_4080_7F80_FFC0_3FBF_0102},
    {1'b1, 1'b0, 6'b001000, 1'b1, 1'b0, 1'b0, 128'h807F_FF00_01C0_4080_7F80_FFC0_3FBF_0102},
    {1'b0, 1'b0, 6'b011111, 1'b0, 1'b0, 1'b0, 128'hDEAD_BEEF_0000_0000_8001_7FFF_FFFF_0003},
    {1'b1, 1'b0, 6'b010000, 1'b1, 1'b0, 1'b0, 128'h8000_7FFF_FFFF_0001_C000_3FFF_8001_0000},
    {1'b0, 1'b0, 6'b011001, 1'b1, 1'b0, 1'b0, 128'h1234_8765_FFC0_0040_7FFF_8000_0FC0_F03F},
    {1'b0, 1'b0, 6'b111111, 1'b1, 1'b0, 1'b0, 128'h8000_0001_7FFF_FFFF_FFFF_FFFF_0000_0003},
    {1'b1, 1'b0, 6'b100000, 1'b1, 1'b0, 1'b0, 128'h8000_0000_7FFF_FFFF_FFFF_FFFF_0000_0001},
    {1'b0, 1'b1, 6'b111111, 1'b1, 1'b0, 1'b0, 128'h8000_0000_0000_0001_7FFF_FFFF_FFFF_FFFF},
    {1'b1, 1'b1, 6'b000000, 1'b1, 1'b0, 1'b0, 128'h8000_0000_0000_0000_7FFF_FFFF_FFFF_FFFF},
    {1'b0, 1'b1, 6'b000000, 1'b0, 1'b0, 1'b0, 128'hFFFF_0000_FFFF_0000_8000_0000_0000_0000},
    {1'b0, 1'b0, 6'b110011, 1'b1, 1'b0, 1'b0, 128'hC001_2345_0000_1FFF_FFFF_F000_0000_1000}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         u = 1'b0;
  logic         l = 1'b0;
  logic [5:0]   imm6 = '0;
  logic         q = 1'b0;
  logic         vd0 = 1'b0;
  logic         vm0 = 1'b0;
  logic [127:0] operand = '0;
  logic         out_valid;
  logic [127:0] result;
  logic         undef_flag;
  logic         other_enc_flag;

  int checks = 0;
  int errors = 0;

  simd_rshr_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .u(u), .l(l), .imm6(imm6), .q(q),
    .vd0(vd0), .vm0(vm0), .operand(operand), .out_valid(out_valid), .result(result),
    .undef_flag(undef_flag), .other_enc_flag(other_enc_flag)
  );

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  // Reference: floor(x / 2^s) plus the bit just below the cut.
  function automatic logic [63:0] ref_word(logic [63:0] w, logic uns, logic [6:0] fld);
    int ew;
    int sh;
    logic [63:0] r;
    r = '0;
    ew = (fld >= 7'd64) ? 64 : (fld >= 7'd32) ? 32 : (fld >= 7'd16) ? 16 : 8;
    sh = 2 * ew - int'(fld);
    for (int e = 0; e < 64 / ew; e++) begin
      logic signed [71:0] x;
      logic signed [71:0] qv;
      for (int b = 0; b < 72; b++)
        x[b] = (b < ew) ? w[e*ew + b] : (uns ? 1'b0 : w[e*ew + ew - 1]);
      qv = x >>> sh;
      if (x[sh-1]) qv = qv + 72'sd1;
      for (int b = 0; b < ew; b++) r[e*ew + b] = qv[b];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic iu, logic il, logic [5:0] iimm, logic iq, logic d0, logic m0,
                       logic [127:0] op);
    @(negedge clk);
    u = iu; l = il; imm6 = iimm; q = iq; vd0 = d0; vm0 = m0; operand = op;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    // Reset state (R1)
    repeat (2) @(negedge clk);
    chk("R1 reset out_valid", 128'(out_valid), 128'd0);
    chk("R1 reset result", result, 128'd0);
    chk("R1 reset flags", 128'({undef_flag, other_enc_flag}), 128'd0);
    rst = 1'b0;

    // Vector table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      logic [138:0] v;
      logic [127:0] exp;
      v = VEC[i];
      issue(v[138], v[137], v[136:131], v[130], v[129], v[128], v[127:0]);
      exp[63:0]   = ref_word(v[63:0], v[138], v[137:131]);
      exp[127:64] = v[130] ? ref_word(v[127:64], v[138], v[137:131]) : 64'd0;
      chk("R2 R3 R4 R5 R6 R7 lanes", result, exp);
      chk("R1 out_valid after strobe", 128'(out_valid), 128'd1);
    end

    // R4 full-width carry, unsigned 64-bit all ones by 64
    issue(1'b1, 1'b1, 6'b000000, 1'b1, 1'b0, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF});
    chk("R4 u64 ones shift 64", result, {64'd1, 64'd1});
    // R4 R5 unsigned 8-bit 0x80 by 8 gives 1, signed gives 0
    issue(1'b1, 1'b0, 6'b001000, 1'b0, 1'b0, 1'b0, {64'h0, 64'h8080_8080_8080_8080});
    chk("R4 u8 0x80 shift 8", result, {64'd0, 64'h0101_0101_0101_0101});
    issue(1'b0, 1'b0, 6'b001000, 1'b0, 1'b0, 1'b0, {64'h0, 64'h8080_8080_8080_8080});
    chk("R5 s8 0x80 shift 8", result, 128'd0);
    // R5 signed 8-bit by 1: 0xFF -> 0x00 (round up), 0xFD -> 0xFF
    issue(1'b0, 1'b0, 6'b001111, 1'b0, 1'b0, 1'b0, {64'h0, 64'h0000_0000_0000_FDFF});
    chk("R5 s8 round by 1", result, {64'd0, 64'h0000_0000_0000_FF00});

    // R8 undefined register numbering
    issue(1'b1, 1'b0, 6'b001111, 1'b1, 1'b1, 1'b0, {64'h1234, 64'h5678});
    chk("R8 undef vd0", 128'({undef_flag, other_enc_flag}), 128'd2);
    chk("R8 undef result", result, 128'd0);
    issue(1'b1, 1'b0, 6'b001111, 1'b1, 1'b0, 1'b1, {64'h1234, 64'h5678});
    chk("R8 undef vm0", 128'(undef_flag), 128'd1);
    issue(1'b1, 1'b0, 6'b001111, 1'b0, 1'b1, 1'b1, {64'h1234, 64'h0000_0000_0000_0503});
    chk("R8 q=0 ignores reg bits", 128'(undef_flag), 128'd0);
    chk("R8 q=0 result", result, {64'd0, 64'h0000_0000_0000_0302});

    // R9 foreign field
    issue(1'b0, 1'b0, 6'b000101, 1'b1, 1'b0, 1'b0, {64'hFFFF, 64'hFFFF});
    chk("R9 other encoding flags", 128'({undef_flag, other_enc_flag}), 128'd1);
    chk("R9 other encoding result", result, 128'd0);

    // R10 hold while idle
    issue(1'b1, 1'b0, 6'b001111, 1'b0, 1'b0, 1'b0, {64'h0, 64'h0000_0000_0000_0404});
    @(negedge clk);
    operand = ~operand; imm6 = 6'b000001; q = 1'b1; vd0 = 1'b1;
    @(negedge clk);
    chk("R10 result held", result, {64'd0, 64'h0000_0000_0000_0202});
    chk("R10 flags held", 128'({undef_flag, other_enc_flag}), 128'd0);
    chk("R1 out_valid low when idle", 128'(out_valid), 128'd0);

    // R1 reset after activity
    issue(1'b1, 1'b0, 6'b001111, 1'b0, 1'b0, 1'b0, {64'h0, 64'h0000_0000_0000_0808});
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears", {result[126:0], out_valid}, 128'd0);
    rst = 1'b0;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule